// File: doc/BRIEF.md
# DDR Read Command Sequencer

This block sits on the controller side of a double-data-rate SDRAM. It turns read requests into column Read commands aimed at rows that are already open, in any bank. Each request carries a bank, a column, the number of data pairs it wants, a flag asking for the row to be closed, and an auto-precharge flag. Because the memory prefetches two elements at a time, a burst of length 2, 4 or 8 carries 1, 2 or 4 pairs. When a request wants fewer pairs than a full burst, the block cuts the burst short. It does this with a Burst Terminate command, or with a Precharge to the same bank when a close is asked for. In both cases the cutting command goes out exactly N cycles after the Read, where N is the pair count. Command spacing on this side does not depend on whether the CAS latency is 2 or 2.5, so that setting is not an input.

The same request port also carries writes. A Write is held back while a read burst is still running. During that time the ready output is low. Ready rises in the cycle after the last pair slot or the cutting command, and the Write goes out on the next cycle. A new Read is taken in any cycle. It cuts off the burst in flight, and any cutting command still pending for the old burst is dropped.

The control is a three-state machine:
- **IDLE** means no burst is open. On an accepted Read the machine goes to COUNT (transition *start*). An accepted Write leaves it in IDLE.
- **COUNT** counts the pair slots down. It moves to LAST when the final slot ends (transition *expire*). It restarts the count on a new Read (transition *restart*).
- **LAST** is the cycle that carries the Burst Terminate, the Precharge or a NOP. It returns to IDLE (transition *release*), or goes back to COUNT on a new Read (transition *restart*).

Top module: `ddr_rdseq`

## Requirements
- R1: After reset, and in every cycle with nothing to issue, the command bus holds NOP. The command is encoded {cs_n,ras_n,cas_n,we_n} = 4'b0111. `req_ready` is high after reset, and the bus carries only the codes NOP, READ, WRITE, BST and PRE.
- R2: An accepted read produces READ (4'b0101) in the next cycle. It carries the request's bank, the column in `cmd_addr[9:0]`, and `cmd_addr[10]` equal to `req_autopre`. All other address bits are zero.
- R3: `cfg_bl` selects the burst length: 1 gives 2 elements (1 pair), 2 gives 4 (2 pairs), and 3 or 0 gives 8 (4 pairs).
- R4: A pair count from 1 up to the full pair count is used as given. A count of 0, or one larger than the full pair count, is treated as the full pair count.
- R5: When `req_close`=0, auto-precharge is off and N is less than the full pair count, BST (4'b0110) appears exactly N cycles after the READ.
- R6: When `req_close`=1 and auto-precharge is off, PRE (4'b0010) appears exactly N cycles after the READ, including when N is the full count. It carries the READ's bank and `cmd_addr[10]`=0.
- R7: When `req_autopre`=1, both `req_close` and the pair count are ignored. The burst runs full, and no BST or PRE follows it.
- R8: A read is accepted in any cycle, including during a burst. The previous burst's pending BST or PRE is then never issued.
- R9: A write request during a burst holds `req_ready` low from the READ cycle through the cycle at N cycles after it. WRITE (4'b0100) then appears N+2 cycles after the READ, with the same address layout as R2. In IDLE a write is accepted at once.
- R10: `req_ready` is always high for a read request. Any accepted request puts a non-NOP command on the bus in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bl | input | 2 | Burst length select |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_bank | input | BA_W | Target bank |
| req_col | input | COL_W | Target column |
| req_pairs | input | PAIR_W | Wanted data pairs (reads) |
| req_close | input | 1 | Close the row with a Precharge after the read |
| req_autopre | input | 1 | Issue the command with auto-precharge |
| req_ready | output | 1 | Request accepted at this clock edge when high |
| cmd | output | 4 | Command {cs_n,ras_n,cas_n,we_n} |
| cmd_bank | output | BA_W | Command bank |
| cmd_addr | output | ADDR_W | Command address |

## Verification
The hardest case to reach is a Read that interrupts a burst whose cutting command is still pending. The new request must land on a cycle after the first Read but before that burst's cutting slot. The bench gets there by issuing two reads on consecutive clocks, with a Precharge-closing request first. The scoreboard then expects only the second burst's Burst Terminate, at its own pair count. The write hold-off is reached the same way: a write request is raised in the very cycle its preceding Read appears. The bench counts how many cycles ready stays low and measures the gap from the Read to the Write.

// File: rtl/ddr_rdseq_pkg.sv
package ddr_rdseq_pkg;

    // Command encoding {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP   = 4'b0111,
        CMD_READ  = 4'b0101,
        CMD_WRITE = 4'b0100,
        CMD_BST   = 4'b0110,
        CMD_PRE   = 4'b0010
    } ddr_cmd_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_COUNT = 2'd1,
        S_LAST  = 2'd2
    } seq_state_e;

    localparam int MAX_PAIRS = 4;

endpackage

// File: rtl/ddr_rdseq_len.sv
module ddr_rdseq_len
    import ddr_rdseq_pkg::*;
#(
    parameter int PAIR_W = 3,
    parameter int CNT_W  = 3
) (
    input  logic [1:0]        cfg_bl,
    input  logic [PAIR_W-1:0] req_pairs,
    input  logic              req_close,
    input  logic              req_autopre,
    output logic [CNT_W-1:0]  eff_pairs,
    output ddr_cmd_e          trail
);

    logic [CNT_W-1:0] full_pairs;

    always_comb begin
        unique case (cfg_bl)
            2'd1:    full_pairs = CNT_W'(1);
            2'd2:    full_pairs = CNT_W'(2);
            default: full_pairs = CNT_W'(MAX_PAIRS);
        endcase

        if (req_autopre || req_pairs == '0 || 32'(req_pairs) > 32'(full_pairs))
            eff_pairs = full_pairs;
        else
            eff_pairs = CNT_W'(req_pairs);

        if (req_autopre)
            trail = CMD_NOP;
        else if (req_close)
            trail = CMD_PRE;
        else if (eff_pairs < full_pairs)
            trail = CMD_BST;
        else
            trail = CMD_NOP;
    end

endmodule

// File: rtl/ddr_rdseq_fsm.sv
module ddr_rdseq_fsm
    import ddr_rdseq_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [CNT_W-1:0] eff_pairs,
    output logic             ready,
    output logic             acc_rd,
    output logic             acc_wr,
    output logic             fire_trail
);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        ready      = (state_q == S_IDLE) || !req_write;
        acc_rd     = req_valid && !req_write;
        acc_wr     = req_valid && req_write && (state_q == S_IDLE);
        fire_trail = 1'b0;
        state_d    = state_q;
        cnt_d      = cnt_q;

        unique case (state_q)
            S_IDLE: begin
                if (acc_rd) begin            // start
                    state_d = S_COUNT;
                    cnt_d   = eff_pairs;
                end
            end
            S_COUNT: begin
                if (acc_rd) begin            // restart
                    cnt_d = eff_pairs;
                end else if (cnt_q == CNT_W'(1)) begin  // expire
                    state_d    = S_LAST;
                    cnt_d      = '0;
                    fire_trail = 1'b1;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            S_LAST: begin
                if (acc_rd) begin            // restart
                    state_d = S_COUNT;
                    cnt_d   = eff_pairs;
                end else begin               // release
                    state_d = S_IDLE;
                end
            end
            default: begin
                state_d = S_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

endmodule

// File: rtl/ddr_rdseq_cmdgen.sv
module ddr_rdseq_cmdgen
    import ddr_rdseq_pkg::*;
#(
    parameter int BA_W   = 2,
    parameter int COL_W  = 10,
    parameter int ADDR_W = 13,
    parameter int AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic              fire_trail,
    input  ddr_cmd_e          trail_in,
    input  logic [BA_W-1:0]   req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_autopre,
    output ddr_cmd_e          cmd_q,
    output logic [BA_W-1:0]   bank_q,
    output logic [ADDR_W-1:0] addr_q
);

    ddr_cmd_e          trail_q;
    logic [BA_W-1:0]   tbank_q;
    logic [ADDR_W-1:0] col_addr;

    always_comb begin
        col_addr              = '0;
        col_addr[COL_W-1:0]   = req_col;
        col_addr[AP_BIT]      = req_autopre;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= CMD_NOP;
            bank_q  <= '0;
            addr_q  <= '0;
            trail_q <= CMD_NOP;
            tbank_q <= '0;
        end else begin
            if (acc_rd) begin
                cmd_q   <= CMD_READ;
                bank_q  <= req_bank;
                addr_q  <= col_addr;
                trail_q <= trail_in;
                tbank_q <= req_bank;
            end else if (acc_wr) begin
                cmd_q  <= CMD_WRITE;
                bank_q <= req_bank;
                addr_q <= col_addr;
            end else if (fire_trail) begin
                cmd_q  <= trail_q;
                bank_q <= tbank_q;
                addr_q <= '0;
            end else begin
                cmd_q  <= CMD_NOP;
                bank_q <= '0;
                addr_q <= '0;
            end
        end
    end

endmodule

// File: rtl/ddr_rdseq.sv
module ddr_rdseq
    import ddr_rdseq_pkg::*;
#(
    parameter int BA_W   = 2,
    parameter int COL_W  = 10,
    parameter int ADDR_W = 13,
    parameter int AP_BIT = 10,
    parameter int PAIR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_bl,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BA_W-1:0]   req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic [PAIR_W-1:0] req_pairs,
    input  logic              req_close,
    input  logic              req_autopre,
    output logic              req_ready,
    output logic [3:0]        cmd,
    output logic [BA_W-1:0]   cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr
);

    localparam int CNT_W = $clog2(MAX_PAIRS + 1);

    logic [CNT_W-1:0] eff_pairs;
    ddr_cmd_e         trail;
    ddr_cmd_e         cmd_q;
    logic             acc_rd, acc_wr, fire_trail;

    ddr_rdseq_len #(.PAIR_W(PAIR_W), .CNT_W(CNT_W)) u_len (
        .cfg_bl      (cfg_bl),
        .req_pairs   (req_pairs),
        .req_close   (req_close),
        .req_autopre (req_autopre),
        .eff_pairs   (eff_pairs),
        .trail       (trail)
    );

    ddr_rdseq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .eff_pairs  (eff_pairs),
        .ready      (req_ready),
        .acc_rd     (acc_rd),
        .acc_wr     (acc_wr),
        .fire_trail (fire_trail)
    );

    ddr_rdseq_cmdgen #(
        .BA_W(BA_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
    ) u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_rd      (acc_rd),
        .acc_wr      (acc_wr),
        .fire_trail  (fire_trail),
        .trail_in    (trail),
        .req_bank    (req_bank),
        .req_col     (req_col),
        .req_autopre (req_autopre),
        .cmd_q       (cmd_q),
        .bank_q      (cmd_bank),
        .addr_q      (cmd_addr)
    );

    assign cmd = cmd_q;

endmodule

// File: rtl/ddr_rdseq_chk.sv
module ddr_rdseq_chk
    import ddr_rdseq_pkg::*;
#(
    parameter int BA_W   = 2,
    parameter int ADDR_W = 13,
    parameter int AP_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_ready,
    input logic [3:0]        cmd,
    input logic [BA_W-1:0]   cmd_bank,
    input logic [ADDR_W-1:0] cmd_addr
);

    logic [2:0]      rd_age;
    logic [BA_W-1:0] rd_bank;
    logic            rd_ap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_age  <= 3'd7;
            rd_bank <= '0;
            rd_ap   <= 1'b0;
        end else if (cmd == CMD_READ) begin
            rd_age  <= 3'd1;
            rd_bank <= cmd_bank;
            rd_ap   <= cmd_addr[AP_BIT];
        end else if (rd_age != 3'd7) begin
            rd_age <= rd_age + 3'd1;
        end
    end

    assert_cmd_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd inside {CMD_NOP, CMD_READ, CMD_WRITE, CMD_BST, CMD_PRE});

    assert_bst_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_BST |-> (rd_age >= 3'd1 && rd_age <= 3'd4));

    assert_pre_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_PRE |-> (cmd_bank == rd_bank && !cmd_addr[AP_BIT]));

    assert_no_trail_after_ap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE || cmd == CMD_BST) |-> !rd_ap);

    assert_write_after_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_WRITE |-> rd_age >= 3'd3);

    assert_read_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |-> req_ready);

    assert_accept_issues_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> cmd != CMD_NOP);

endmodule

bind ddr_rdseq ddr_rdseq_chk #(
    .BA_W(BA_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .cmd       (cmd),
    .cmd_bank  (cmd_bank),
    .cmd_addr  (cmd_addr)
);

// File: tb/test_ddr_rdseq.sv
`timescale 1ns/1ps
module test_ddr_rdseq;

    localparam logic [3:0] NOP = 4'b0111, RD = 4'b0101, WR = 4'b0100,
                           BST = 4'b0110, PRE = 4'b0010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_bl = 2'd3;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [9:0]  req_col = '0;
    logic [2:0]  req_pairs = '0;
    logic        req_close = 1'b0, req_autopre = 1'b0;
    logic        req_ready;
    logic [3:0]  cmd;
    logic [1:0]  cmd_bank;
    logic [12:0] cmd_addr;

    int tests = 0, fails = 0, cyc = 0, last_rd = 0;

    typedef struct {
        logic [3:0]  cmd;
        logic [1:0]  bank;
        logic [12:0] addr;
        int          gap;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    ddr_rdseq i_ddr_rdseq (
        .clk(clk), .rst_n(rst_n), .cfg_bl(cfg_bl), .req_valid(req_valid),
        .req_write(req_write), .req_bank(req_bank), .req_col(req_col),
        .req_pairs(req_pairs), .req_close(req_close), .req_autopre(req_autopre),
        .req_ready(req_ready), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop and compare every non-NOP command
    always @(negedge clk) begin
        if (rst_n && cmd !== NOP) begin
            exp_t e;
            int   gap;
            gap = cyc - last_rd;
            tests++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL unexpected command: cmd=%b bank=%0d addr=%h expected none (R8/R7)",
                         cmd, cmd_bank, cmd_addr);
            end else begin
                e = q.pop_front();
                if (cmd !== e.cmd || cmd_bank !== e.bank || cmd_addr !== e.addr ||
                    (e.gap >= 0 && gap != e.gap)) begin
                    fails++;
                    $display("FAIL %s: cmd=%b bank=%0d addr=%h gap=%0d expected cmd=%b bank=%0d addr=%h gap=%0d",
                             e.tag, cmd, cmd_bank, cmd_addr, gap, e.cmd, e.bank, e.addr, e.gap);
                end
            end
            if (cmd === RD) last_rd = cyc;
        end
    end

    function automatic int full_of(input int bl);
        return (bl == 1) ? 1 : (bl == 2) ? 2 : 4;
    endfunction

    function automatic int eff_of(input int bl, input int pairs, input bit ap);
        int f;
        f = full_of(bl);
        return (ap || pairs == 0 || pairs > f) ? f : pairs;
    endfunction

    function automatic logic [12:0] caddr(input logic [9:0] col, input bit ap);
        return {2'b00, ap, col};
    endfunction

    function automatic void push(input logic [3:0] c, input logic [1:0] b,
                                 input logic [12:0] a, input int g, input string t);
        exp_t e;
        e.cmd = c; e.bank = b; e.addr = a; e.gap = g; e.tag = t;
        q.push_back(e);
    endfunction

    function automatic void check(input bit ok, input string msg, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", msg, act, exp);
        end
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: issue one read (called at a negedge)
    task automatic rd(input int bl, input logic [1:0] b, input logic [9:0] c,
                      input int pairs, input bit close, input bit ap,
                      input bit exp_trail, input string tag);
        int n, f;
        n = eff_of(bl, pairs, ap);
        f = full_of(bl);
        cfg_bl = 2'(bl); req_valid = 1'b1; req_write = 1'b0; req_bank = b;
        req_col = c; req_pairs = 3'(pairs); req_close = close; req_autopre = ap;
        push(RD, b, caddr(c, ap), -1, "R2");
        if (exp_trail && !ap) begin
            if (close)      push(PRE, b, 13'h0, n, tag);
            else if (n < f) push(BST, b, 13'h0, n, tag);
        end
        #1 check(req_ready === 1'b1, "R10 read ready", int'(req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Driver: issue one write and measure the hold-off
    task automatic wr(input logic [1:0] b, input logic [9:0] c, input int exp_waits,
                      input int exp_gap, input string tag);
        int waits;
        waits = 0;
        req_valid = 1'b1; req_write = 1'b1; req_bank = b; req_col = c;
        req_autopre = 1'b0; req_close = 1'b0;
        push(WR, b, caddr(c, 1'b0), exp_gap, tag);
        forever begin
            #1;
            if (req_ready) break;
            waits++;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check(waits == exp_waits, {tag, " ready low cycles"}, waits, exp_waits);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(cmd === NOP, "R1 cmd after reset", int'(cmd), int'(NOP));
        check(req_ready === 1'b1, "R1 ready after reset", int'(req_ready), 1);

        rd(3, 2'd1, 10'h155, 4, 0, 0, 1, "R2");  idle(8);   // full BL8, nothing trails
        rd(3, 2'd2, 10'h0a3, 2, 0, 0, 1, "R5");  idle(8);   // BST after 2
        rd(3, 2'd3, 10'h3ff, 3, 1, 0, 1, "R6");  idle(8);   // PRE after 3
        rd(3, 2'd0, 10'h001, 4, 1, 0, 1, "R6");  idle(8);   // PRE after full 4
        rd(2, 2'd1, 10'h010, 1, 0, 0, 1, "R3");  idle(8);   // BL4: BST after 1
        rd(2, 2'd2, 10'h020, 0, 1, 0, 1, "R4");  idle(8);   // 0 -> 2 pairs
        rd(2, 2'd3, 10'h030, 7, 1, 0, 1, "R4");  idle(8);   // 7 -> 2 pairs
        rd(1, 2'd0, 10'h040, 1, 1, 0, 1, "R3");  idle(8);   // BL2: PRE after 1
        rd(1, 2'd1, 10'h050, 1, 0, 0, 1, "R3");  idle(8);   // BL2 full: nothing
        rd(0, 2'd2, 10'h060, 0, 1, 0, 1, "R3");  idle(8);   // code 0 -> BL8, PRE after 4
        rd(3, 2'd3, 10'h070, 1, 1, 1, 1, "R7");  idle(8);   // autopre: nothing trails
        // R8: second read interrupts a pending PRE
        rd(3, 2'd1, 10'h080, 3, 1, 0, 0, "R8");
        rd(3, 2'd2, 10'h090, 2, 0, 0, 1, "R8");  idle(8);
        // R9: write raised in the READ cycle
        rd(3, 2'd0, 10'h0a0, 2, 0, 0, 1, "R5");
        wr(2'd0, 10'h0b0, 3, 4, "R9");           idle(6);
        rd(2, 2'd1, 10'h0c0, 2, 0, 0, 1, "R9");
        wr(2'd1, 10'h0d0, 3, 4, "R9");           idle(6);
        rd(3, 2'd2, 10'h0e0, 4, 1, 0, 1, "R6");
        wr(2'd2, 10'h0f0, 5, 6, "R9");           idle(6);
        // R9: write when idle goes straight through
        wr(2'd3, 10'h123, 0, -1, "R9");          idle(4);

        check(q.size() == 0, "R8 commands left outstanding", q.size(), 0);
        check(cmd === NOP, "R1 idle bus", int'(cmd), int'(NOP));
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule